// File: doc/BRIEF.md
# Radix-4 Folded Significand Squarer

This block squares an unsigned 24-bit significand and returns the exact 48-bit square, with every low-order bit kept so that a downstream rounder can see the whole product. It is purely combinational. It has no clock, no reset and no handshake: the square follows the input within the same cycle.

It does not use a two-operand multiplier. The operand is recoded into radix-4 digits in {-2,-1,0,+1,+2}, with a zero below bit 0. Because the operand is unsigned, one extra top digit is added and takes only the values 0 or +1.

The partial-product array is folded using the symmetry of a square. For digits d_k:

  x^2 = sum(d_l^2 * 16^l) + 2 * sum over k<l of (d_k * d_l * 4^(k+l))

Each distinct cross product is therefore formed only once, pre-doubled, and the diagonal digit term is merged into the same row. Row l carries d_l times a short field. That field is the operand bits below the digit, shifted left by one, with a small signed head on top. Row widths shrink toward the top of the array.

The rows and one vector of negation correction bits are reduced by a carry-save tree. A single carry-propagate adder then forms the result, low-order bits first. No MSB-first approximation is made.

Top module: `sq_radix4_fold`

## Requirements
- R1: For every 24-bit input x, sq_o equals x*x exactly on all 48 bits.
- R2: Recoding uses 13 overlapping bit triplets {x[2k+1], x[2k], x[2k-1]}, with x[-1] = 0 and zeros above bit 23. Inputs whose bits cause long chains of negative digits (runs of ones, alternating bit patterns, repeated nibble patterns) still square exactly.
- R3: The block is combinational. A zero input gives a zero output, and the result for any input is valid in the same cycle the input is applied.
- R4: The all-ones input 0xFFFFFF gives 2^48 - 2^25 + 1 = 0xFFFFFE000001.
- R5: Output bit 1 is always 0, and output bit 0 always equals input bit 0.
- R6: A single-bit input 2^k, for k from 0 to 23, gives exactly 2^(2k).
- R7: Inputs with bit 23 set are squared correctly through the extra top digit, which is never negative. 2^23 gives 2^46, 0x800001 gives 2^46 + 2^24 + 1, and 0x7FFFFF gives 2^46 - 2^24 + 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 24 | Unsigned significand to be squared |
| sq_o | output | 48 | Exact unsigned square of x_i |

## Verification
Every result is due zero cycles after its stimulus, because no register lies between x_i and sq_o. The driver applies each operand on a rising clock edge and pushes the expected square into the scoreboard queue. The monitor pops and compares at the following falling edge, half a period later, when the combinational paths have settled. Only one item is ever outstanding, so each comparison lines up with the operand that produced it.

// File: rtl/sq_pkg.sv
package sq_pkg;

  // Radix-4 digit: magnitude one-hot (one/two), sign in neg
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } bdig_t;

  // operands left after lvl levels of 3:2 compression
  function automatic int csa_cnt(input int n0, input int lvl);
    int n;
    n = n0;
    for (int i = 0; i < lvl; i++) n = n - n / 3;
    return n;
  endfunction

  function automatic int csa_levels(input int n0);
    int n;
    int l;
    n = n0;
    l = 0;
    while (n > 2) begin
      n = n - n / 3;
      l++;
    end
    return l;
  endfunction

endpackage

// File: rtl/sq_booth_rec.sv
module sq_booth_rec #(
  parameter int WIDTH = 24,
  parameter int NDIG  = WIDTH / 2 + 1
) (
  input  logic [WIDTH-1:0]   x_i,
  output sq_pkg::bdig_t      dig_o [NDIG]
);

  localparam int XPW = WIDTH + 3;

  // zero below bit 0, two zeros above the top bit
  logic [XPW-1:0] xp;
  assign xp = {2'b00, x_i, 1'b0};

  for (genvar k = 0; k < NDIG; k++) begin : g_dig
    logic b2, b1, b0;
    assign b2 = xp[2*k+2];
    assign b1 = xp[2*k+1];
    assign b0 = xp[2*k];

    assign dig_o[k].one = b1 ^ b0;
    assign dig_o[k].two = (b2 & ~b1 & ~b0) | (~b2 & b1 & b0);
    assign dig_o[k].neg = b2 & ~(b1 & b0);

    always_comb begin
      // R2
      digit_code_chk: assert ($onehot0({dig_o[k].one, dig_o[k].two}) &&
                              (!dig_o[k].neg || dig_o[k].one || dig_o[k].two))
        else $error("digit %0d has an illegal code", k);
    end
  end

endmodule

// File: rtl/sq_row.sv
module sq_row #(
  parameter int PW  = 48,
  parameter int IDX = 0,
  parameter int LW  = (IDX == 0) ? 1 : 2 * IDX
) (
  input  logic [LW-1:0]    low_i,   // x[2*IDX-1:0], or the implicit zero for row 0
  input  sq_pkg::bdig_t    dig_i,
  output logic [PW-1:0]    row_o
);

  localparam int TW = 2 * IDX + 3;
  localparam int SW = PW - 2 * IDX;

  logic signed [2:0] d_s;
  logic signed [2:0] h_s;
  logic              xm1;
  logic [TW-1:0]     t;
  logic [SW-1:0]     t_ext;
  logic [SW-1:0]     m;
  logic [SW-1:0]     mv;

  assign xm1 = low_i[LW-1];

  always_comb begin
    d_s = dig_i.two ? 3'sd2 : (dig_i.one ? 3'sd1 : 3'sd0);
    if (dig_i.neg) d_s = -d_s;
    // head of the folded field: digit minus the borrow from the lower digits
    h_s = d_s - $signed({2'b00, xm1});
  end

  if (IDX == 0) begin : g_base
    assign t = h_s;
  end else begin : g_fold
    assign t = {h_s, low_i[LW-2:0], 1'b0};
  end

  assign t_ext = SW'($signed(t));
  assign m     = dig_i.two ? {t_ext[SW-2:0], 1'b0} : (dig_i.one ? t_ext : '0);
  assign mv    = dig_i.neg ? ~m : m;   // +1 supplied by the correction vector

  if (IDX == 0) begin : g_noshift
    assign row_o = mv;
  end else begin : g_shift
    assign row_o = {mv, {(2*IDX){1'b0}}};
  end

endmodule

// File: rtl/sq_csa3.sv
module sq_csa3 #(
  parameter int W = 48
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);

  logic [W-2:0] maj;

  assign s_o = a_i ^ b_i ^ c_i;
  assign maj = (a_i[W-2:0] & b_i[W-2:0]) | (a_i[W-2:0] & c_i[W-2:0]) |
               (b_i[W-2:0] & c_i[W-2:0]);
  assign c_o = {maj, 1'b0};

  always_comb begin
    // R1
    csa_sum_chk: assert (W'(s_o + c_o) == W'(a_i + b_i + c_i))
      else $error("carry-save stage lost value");
  end

endmodule

// File: rtl/sq_csa_tree.sv
module sq_csa_tree #(
  parameter int PW   = 48,
  parameter int NOPS = 14
) (
  input  logic [PW-1:0] ops_i [NOPS],
  output logic [PW-1:0] sum_o,
  output logic [PW-1:0] carry_o
);

  localparam int NLEV = sq_pkg::csa_levels(NOPS);

  for (genvar l = 0; l <= NLEV; l++) begin : g_lvl
    localparam int N = sq_pkg::csa_cnt(NOPS, l);
    logic [PW-1:0] v [N];

    if (l == 0) begin : g_in
      for (genvar i = 0; i < N; i++) begin : g_cp
        assign v[i] = ops_i[i];
      end
    end else begin : g_red
      localparam int NP = sq_pkg::csa_cnt(NOPS, l - 1);
      localparam int NG = NP / 3;
      for (genvar g = 0; g < NG; g++) begin : g_csa
        sq_csa3 #(.W(PW)) i_csa (
          .a_i (g_lvl[l-1].v[3*g]),
          .b_i (g_lvl[l-1].v[3*g+1]),
          .c_i (g_lvl[l-1].v[3*g+2]),
          .s_o (v[2*g]),
          .c_o (v[2*g+1])
        );
      end
      for (genvar r = 0; r < NP - 3 * NG; r++) begin : g_pass
        assign v[2*NG+r] = g_lvl[l-1].v[3*NG+r];
      end
    end
  end

  assign sum_o   = g_lvl[NLEV].v[0];
  assign carry_o = g_lvl[NLEV].v[1];

endmodule

// File: rtl/sq_radix4_fold.sv
module sq_radix4_fold #(
  parameter int WIDTH = 24
) (
  input  logic [WIDTH-1:0]   x_i,
  output logic [2*WIDTH-1:0] sq_o
);

  localparam int PW   = 2 * WIDTH;
  localparam int NDIG = WIDTH / 2 + 1;
  localparam int NOPS = NDIG + 1;

  sq_pkg::bdig_t dig [NDIG];
  logic [PW-1:0] rows [NDIG];
  logic [PW-1:0] corr;
  logic [PW-1:0] ops  [NOPS];
  logic [PW-1:0] s_vec, c_vec;

  sq_booth_rec #(.WIDTH(WIDTH), .NDIG(NDIG)) i_rec (
    .x_i   (x_i),
    .dig_o (dig)
  );

  for (genvar k = 0; k < NDIG; k++) begin : g_row
    localparam int LW = (k == 0) ? 1 : 2 * k;
    logic [LW-1:0] low;
    if (k == 0) begin : g_z
      assign low = 1'b0;
    end else begin : g_x
      assign low = x_i[2*k-1:0];
    end

    sq_row #(.PW(PW), .IDX(k), .LW(LW)) i_row (
      .low_i (low),
      .dig_i (dig[k]),
      .row_o (rows[k])
    );

    assign ops[k] = rows[k];
  end

  // two's complement +1 for every negated row, at the row's base weight
  always_comb begin
    corr = '0;
    for (int k = 0; k < NDIG; k++) corr[2*k] = dig[k].neg;
  end
  assign ops[NDIG] = corr;

  sq_csa_tree #(.PW(PW), .NOPS(NOPS)) i_tree (
    .ops_i   (ops),
    .sum_o   (s_vec),
    .carry_o (c_vec)
  );

  assign sq_o = s_vec + c_vec;

  logic signed [PW+1:0] rec;
  always_comb begin
    rec = '0;
    for (int k = 0; k < NDIG; k++) begin
      int v;
      v = dig[k].two ? 2 : (dig[k].one ? 1 : 0);
      if (dig[k].neg) v = -v;
      rec = rec + ((PW+2)'(v) <<< (2 * k));
    end
  end

  always_comb begin
    // R1
    sq_exact_chk: assert (sq_o == PW'(x_i) * PW'(x_i))
      else $error("square mismatch for %h", x_i);
    // R2
    digit_value_chk: assert (rec == (PW+2)'(x_i))
      else $error("digits do not rebuild the operand");
    // R5
    sq_low_bits_chk: assert (sq_o[1] == 1'b0 && sq_o[0] == x_i[0])
      else $error("low square bits wrong");
    // R7
    top_digit_chk: assert (!dig[NDIG-1].neg && !dig[NDIG-1].two)
      else $error("top digit out of range");
  end

endmodule

// File: tb/test_sq_radix4_fold.sv
module test_sq_radix4_fold;

  localparam int W  = 24;
  localparam int PW = 48;

  typedef struct {
    logic [W-1:0]  x;
    logic [PW-1:0] exp;
    string         req;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  x_i = '0;
  logic [PW-1:0] sq_o;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  item_t q[$];

  always #2 clk = ~clk;

  sq_radix4_fold #(.WIDTH(W)) i_sq_radix4_fold (
    .x_i  (x_i),
    .sq_o (sq_o)
  );

  function automatic logic [PW-1:0] sq_ref(input logic [W-1:0] x);
    return PW'(x) * PW'(x);
  endfunction

  task automatic push(input logic [W-1:0] x, input logic [PW-1:0] e, input string r);
    item_t it;
    @(posedge clk);
    x_i = x;
    it.x   = x;
    it.exp = e;
    it.req = r;
    q.push_back(it);
  endtask

  // monitor: result is combinational, checked half a period after drive
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (sq_o !== it.exp) begin
          errors++;
          $display("FAIL %s x=%h actual=%h expected=%h", it.req, it.x, sq_o, it.exp);
        end
        if (it.req == "R5") begin
          checks++;
          if (sq_o[1] !== 1'b0 || sq_o[0] !== it.x[0]) begin
            errors++;
            $display("FAIL R5 x=%h actual low bits=%b expected=%b", it.x, sq_o[1:0],
                     {1'b0, it.x[0]});
          end
        end
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    rst_n = 1'b1;

    // R3: zero in, zero out, same cycle
    push('0, '0, "R3");

    // R4: all-ones closed form
    push({W{1'b1}}, PW'((64'd1 << 48) - (64'd1 << 25) + 64'd1), "R4");

    // R6: every power of two
    for (int k = 0; k < W; k++) push(W'(1) << k, PW'(1) << (2 * k), "R6");

    // R7: top bit set
    push(24'h800000, PW'(1) << 46, "R7");
    push(24'h800001, (PW'(1) << 46) + (PW'(1) << 24) + PW'(1), "R7");
    push(24'h7FFFFF, (PW'(1) << 46) - (PW'(1) << 24) + PW'(1), "R7");
    push(24'hC00000, PW'(9) << 44, "R7");

    // R2: recoding stress patterns
    push(24'h555555, sq_ref(24'h555555), "R2");
    push(24'hAAAAAA, sq_ref(24'hAAAAAA), "R2");
    push(24'h333333, sq_ref(24'h333333), "R2");
    push(24'h0F0F0F, sq_ref(24'h0F0F0F), "R2");
    push(24'hF0F0F0, sq_ref(24'hF0F0F0), "R2");
    for (int k = 1; k <= W; k++) begin
      logic [W-1:0] run;
      run = W'((64'd1 << k) - 64'd1);
      push(run, sq_ref(run), "R2");
      push(~run, sq_ref(~run), "R2");
    end

    // R5: low bits on odd and even operands
    for (int k = 0; k < 64; k++) begin
      logic [W-1:0] v;
      v = W'($urandom);
      push(v, sq_ref(v), "R5");
    end

    // R1: broad random sweep
    for (int k = 0; k < 3000; k++) begin
      logic [W-1:0] v;
      v = W'($urandom);
      push(v, sq_ref(v), "R1");
    end

    // R3: back to zero after nonzero traffic
    push('0, '0, "R3");

    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule